// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction per clock. It holds its own program counter, a 32-entry general register file, an arithmetic/logic unit, immediate sign extension, a branch-target adder and a jump-address former. Instruction and data storage are word arrays inside the block. They are filled through a load port while the core is held in reset.

Decoding has two levels. A main decoder turns the 6-bit opcode into datapath steering and a 2-bit ALU class. A second stage resolves that class, together with the function field of register-register instructions, into the ALU operation. The supported set is word load, word store, add, subtract, and, or, nor, set-on-less-than, branch-if-equal and unconditional jump. An unknown instruction raises one flag and signed overflow on add or subtract raises another. Either one cancels all architectural writes of that instruction. Current PC, register write-back and data-store activity are visible on the ports.

The reset input clears asynchronously. Its release is synchronised inside the block, and the first instruction (at address 0) retires on the third rising edge after release.

Top module: `scpu_core`

## Requirements
- R1: While reset is applied, and for the two edges after its release, the PC reads 0 and neither the register file nor data storage is written.
- R2: Any instruction that is neither a branch (opcode 000100) nor a jump (opcode 000010) advances the PC by 4.
- R3: Opcode 000000 is register-register: rs = bits 25:21, rt = bits 20:16, rd = bits 15:11, function = bits 5:0. The result is written to rd. Functions: 32 add, 34 subtract, 36 and, 37 or, 39 nor, 42 signed set-on-less-than (result 1 or 0).
- R4: Opcode 100011 loads rt from data word (rs + sign-extended bits 15:0) with address bits 1:0 ignored. The 64-word data array takes its index from address bits 7:2, and higher bits are ignored.
- R5: Opcode 101011 stores rt to the data word addressed as in R4, shows the byte address and data on the store ports, and writes no register.
- R6: Opcode 000100 compares rs with rt. When they are equal the next PC is PC + 4 + (sign-extended offset × 4). Otherwise it is PC + 4.
- R7: Opcode 000010 sets the next PC to PC[31:28], then bits 25:0 of the instruction, then two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it is reported on the write-back port but leaves its value unchanged.
- R9: Any other opcode, or opcode 000000 with any other function code, raises the illegal flag for that cycle and suppresses both register and store writes. The PC advances by 4.
- R10: Signed overflow of a register-register add or subtract raises the overflow flag and suppresses the register write. The PC advances by 4.
- R11: A register written by one instruction holds the new value when read by the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchroniser |
| ld_imem_we | input | 1 | Write one word into instruction storage |
| ld_dmem_we | input | 1 | Write one word into data storage |
| ld_idx | input | 6 | Word index for the load port |
| ld_data | input | 32 | Word written by the load port |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write-back happens at the end of this cycle |
| rf_waddr_o | output | 5 | Destination register of the write-back |
| rf_wdata_o | output | 32 | Write-back value |
| dm_we_o | output | 1 | Data store happens at the end of this cycle |
| dm_addr_o | output | 32 | Byte address computed for the data access |
| dm_wdata_o | output | 32 | Store data |
| illegal_o | output | 1 | Current instruction is not decodable |
| ovf_o | output | 1 | Current add or subtract overflowed |

## Verification
Register write-back and operand read meet when an instruction consumes a register written by the instruction before it, and when a load reads back a word that an earlier store placed at a misaligned address. Exception detection and write cancellation meet whenever an overflowing add or subtract, or an undecodable word, lands in the same cycle as an enabled write. The program mixes seeded random register-register operations over a shared pool of registers, including register 0, with directed overflow, illegal, store/load, branch and jump cases. Every cycle, a bench reference model built from the requirements predicts the PC, the write-back and store ports, and the two flags.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  // ALU class chosen by the main decoder
  typedef enum logic [1:0] {
    ACLS_ADD   = 2'b00,
    ACLS_SUB   = 2'b01,
    ACLS_FUNCT = 2'b10
  } alu_cls_e;

  // {invert a, invert b, result select}
  typedef enum logic [3:0] {
    AFN_AND = 4'b0000,
    AFN_OR  = 4'b0001,
    AFN_ADD = 4'b0010,
    AFN_SUB = 4'b0110,
    AFN_SLT = 4'b0111,
    AFN_NOR = 4'b1100
  } alu_fn_e;

  typedef struct packed {
    logic     dst_rd;
    logic     src_imm;
    logic     wb_mem;
    logic     reg_we;
    logic     mem_rd;
    logic     mem_we;
    logic     branch;
    alu_cls_e acls;
    logic     jump;
    logic     bad_op;
  } ctl_t;

endpackage

// File: rtl/scpu_rst_sync.sv
module scpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/scpu_main_dec.sv
module scpu_main_dec
  import scpu_pkg::*;
(
  input  logic [5:0] opcode,
  output ctl_t       ctl
);
  always_comb begin
    ctl      = '0;
    ctl.acls = ACLS_ADD;
    case (opcode)
      OPC_REG: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.acls   = ACLS_FUNCT;
      end
      OPC_LOAD: begin
        ctl.src_imm = 1'b1;
        ctl.wb_mem  = 1'b1;
        ctl.reg_we  = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      OPC_STORE: begin
        ctl.src_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.acls   = ACLS_SUB;
      end
      OPC_JUMP: begin
        ctl.jump = 1'b1;
      end
      default: begin
        ctl.bad_op = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/scpu_alu_ctl.sv
module scpu_alu_ctl
  import scpu_pkg::*;
(
  input  alu_cls_e   acls,
  input  logic [5:0] funct,
  output alu_fn_e    fn,
  output logic       bad_funct,
  output logic       arith
);
  always_comb begin
    fn        = AFN_ADD;
    bad_funct = 1'b0;
    arith     = 1'b0;
    case (acls)
      ACLS_ADD: fn = AFN_ADD;
      ACLS_SUB: fn = AFN_SUB;
      default: begin
        case (funct)
          FN_ADD: begin fn = AFN_ADD; arith = 1'b1; end
          FN_SUB: begin fn = AFN_SUB; arith = 1'b1; end
          FN_AND: fn = AFN_AND;
          FN_OR:  fn = AFN_OR;
          FN_NOR: fn = AFN_NOR;
          FN_SLT: fn = AFN_SLT;
          default: bad_funct = 1'b1;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero,
  output logic         ovf
);
  logic [3:0]   fbits;
  logic [W-1:0] a_m, b_m, sum;
  logic         ovf_raw, less;

  always_comb begin
    fbits   = fn;
    a_m     = fbits[3] ? ~a : a;
    b_m     = fbits[2] ? ~b : b;
    sum     = a_m + b_m + {{(W-1){1'b0}}, fbits[2]};
    ovf_raw = (a_m[W-1] == b_m[W-1]) && (sum[W-1] != a_m[W-1]);
    less    = sum[W-1] ^ ovf_raw;
    case (fbits[1:0])
      2'b00:   y = a_m & b_m;
      2'b01:   y = a_m | b_m;
      2'b10:   y = sum;
      default: y = {{(W-1){1'b0}}, less};
    endcase
    zero = (y == '0);
    ovf  = ovf_raw && (fbits[1:0] == 2'b10);
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs_q [NREG];
  logic         wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/scpu_wordmem.sv
module scpu_wordmem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_imem_we,
  input  logic            ld_dmem_we,
  input  logic [LAW-1:0]  ld_idx,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o,
  output logic            illegal_o,
  output logic            ovf_o
);
  logic            rst_int_n;
  logic [XLEN-1:0] pc_q, pc_d, pc_inc, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, imm_sx;
  logic [5:0]      opcode, funct;
  logic [RAW-1:0]  rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0] rs_rdata, rt_rdata, alu_b, alu_y, dm_rdata, wb_data;
  ctl_t            ctl;
  alu_fn_e         afn;
  logic            bad_funct, arith, alu_zero, alu_ovf;
  logic            illegal, ovf, exc, take_br, rf_we, dm_we;
  logic            dmem_we;
  logic [DAW-1:0]  dmem_waddr;
  logic [XLEN-1:0] dmem_wdata;

  scpu_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  // instruction storage
  scpu_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN)) i_imem (
    .clk(clk), .we(ld_imem_we), .waddr(ld_idx[IAW-1:0]), .wdata(ld_data),
    .raddr(pc_q[IAW+1:2]), .rdata(instr)
  );

  assign opcode = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign funct  = instr[5:0];
  assign imm_sx = {{16{instr[15]}}, instr[15:0]};

  scpu_main_dec i_dec (.opcode(opcode), .ctl(ctl));

  scpu_alu_ctl i_actl (
    .acls(ctl.acls), .funct(funct), .fn(afn), .bad_funct(bad_funct), .arith(arith)
  );

  scpu_regfile #(.NREG(NREG), .W(XLEN)) i_rf (
    .clk(clk), .rst_n(rst_int_n), .we(rf_we), .waddr(wr_idx), .wdata(wb_data),
    .ra1(rs_idx), .rd1(rs_rdata), .ra2(rt_idx), .rd2(rt_rdata)
  );

  assign alu_b = ctl.src_imm ? imm_sx : rt_rdata;

  scpu_alu #(.W(XLEN)) i_alu (
    .a(rs_rdata), .b(alu_b), .fn(afn), .y(alu_y), .zero(alu_zero), .ovf(alu_ovf)
  );

  // exceptions cancel architectural writes of the current instruction
  always_comb begin
    illegal = ctl.bad_op || (ctl.acls == ACLS_FUNCT && bad_funct);
    ovf     = alu_ovf && arith;
    exc     = illegal || ovf;
    rf_we   = ctl.reg_we && !exc && rst_int_n;
    dm_we   = ctl.mem_we && !exc && rst_int_n;
    wr_idx  = ctl.dst_rd ? rd_idx : rt_idx;
  end

  // data storage, load port has priority (used only while in reset)
  always_comb begin
    dmem_we    = ld_dmem_we || dm_we;
    dmem_waddr = ld_dmem_we ? ld_idx[DAW-1:0] : alu_y[DAW+1:2];
    dmem_wdata = ld_dmem_we ? ld_data : rt_rdata;
  end

  scpu_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN)) i_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
    .raddr(alu_y[DAW+1:2]), .rdata(dm_rdata)
  );

  assign wb_data = ctl.wb_mem ? dm_rdata : alu_y;

  // next-PC selection
  always_comb begin
    pc_inc  = pc_q + 32'd4;
    br_tgt  = pc_inc + {imm_sx[29:0], 2'b00};
    jmp_tgt = {pc_q[31:28], instr[25:0], 2'b00};
    take_br = ctl.branch && alu_zero;
    if (ctl.jump)   pc_d = jmp_tgt;
    else if (take_br) pc_d = br_tgt;
    else            pc_d = pc_inc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pc_q <= '0;
    else            pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we;
  assign rf_waddr_o = wr_idx;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = dm_we;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_rdata;
  assign illegal_o  = illegal;
  assign ovf_o      = ovf;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], pc_q[31:IAW+2], alu_y[1:0], alu_y[31:DAW+2],
                         instr[10:6], ctl.mem_rd, ld_idx};
endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk
  import scpu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            rst_int_n,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] instr,
  input logic            rf_we_o,
  input logic            dm_we_o,
  input logic            illegal_o,
  input logic            ovf_o,
  input logic [4:0]      rs_idx,
  input logic [XLEN-1:0] rs_rdata
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) !rst_n |=> pc_o == '0);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (instr[31:26] != OPC_BEQ && instr[31:26] != OPC_JUMP) |=> pc_o == $past(pc_o) + 32'd4);

  // R7
  jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (instr[31:26] == OPC_JUMP) |=> pc_o == {$past(pc_o[31:28]), $past(instr[25:0]), 2'b00});

  // R8
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rs_idx == 5'd0) |-> rs_rdata == '0);

  // R9
  illegal_block_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    illegal_o |-> (!rf_we_o && !dm_we_o));

  // R10
  ovf_block_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovf_o |-> (!rf_we_o && !dm_we_o));

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    dm_we_o |-> !rf_we_o);
endmodule

bind scpu_core scpu_core_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n), .pc_o(pc_o), .instr(instr),
  .rf_we_o(rf_we_o), .dm_we_o(dm_we_o), .illegal_o(illegal_o), .ovf_o(ovf_o),
  .rs_idx(rs_idx), .rs_rdata(rs_rdata)
);

// File: tb/test_scpu_core.sv
`timescale 1ns/1ps
module test_scpu_core;
  localparam int NW = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_imem_we, ld_dmem_we;
  logic [5:0]  ld_idx;
  logic [31:0] ld_data;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o, illegal_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] im [NW];
  logic [31:0] dm [NW];
  logic [31:0] rf [32];
  logic [31:0] m_pc;
  int          prev_w = -1;

  always #10 clk = ~clk;

  scpu_core i_scpu_core (
    .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
    .ld_idx(ld_idx), .ld_data(ld_data), .pc_o(pc_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o), .illegal_o(illegal_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'b000010, 26'(word)};
  endfunction

  function automatic logic [5:0] pick_fn(int k);
    case (k % 6)
      0: return 6'd32;
      1: return 6'd34;
      2: return 6'd36;
      3: return 6'd37;
      4: return 6'd39;
      default: return 6'd42;
    endcase
  endfunction

  task automatic build_prog();
    int s;
    s = $urandom(32'h5eed_0042);
    for (int i = 0; i < NW; i++) begin
      im[i] = 32'd0;
      dm[i] = $urandom;
    end
    dm[2] = 32'd0; dm[3] = 32'h7fff_ffff; dm[4] = 32'h8000_0000; dm[5] = 32'hffff_ffff;
    dm[8] = 32'd5; dm[9] = 32'h7fff_ffff; dm[10] = 32'd1; dm[11] = 32'h8000_0000;
    for (int k = 1; k <= 12; k++) im[k-1] = enc_i(6'b100011, 0, k, 4*(k-1));
    for (int i = 12; i < 36; i++)
      im[i] = enc_r($urandom_range(0, 8), $urandom_range(0, 8), $urandom_range(0, 8),
                    pick_fn($urandom_range(0, 5)));
    im[36] = enc_r(10, 11, 13, 6'd32);           // overflow add
    im[37] = enc_r(12, 11, 13, 6'd34);           // overflow sub
    im[38] = enc_r(9, 9, 0, 6'd32);              // write to r0
    im[39] = enc_r(0, 9, 14, 6'd37);             // read r0
    im[40] = 32'hFC00_0000;                      // unknown opcode
    im[41] = enc_r(9, 9, 15, 6'h01);             // unknown funct
    im[42] = enc_i(6'b101011, 9, 14, 40);        // store to misaligned address 45
    im[43] = enc_i(6'b100011, 0, 15, 44);        // load word 11
    im[44] = enc_r(15, 15, 16, 6'd32);           // back-to-back use
    im[45] = enc_i(6'b000100, 9, 0, 5);          // not taken
    im[46] = enc_i(6'b000100, 15, 14, 1);        // taken, skips 47
    im[47] = 32'hFC00_0000;
    im[48] = enc_j(51);
    im[49] = 32'hFC00_0000;
    im[50] = 32'hFC00_0000;
    im[51] = enc_i(6'b101011, 0, 16, 256);       // index wraps to 0
    im[52] = enc_i(6'b100011, 0, 17, 0);
    im[53] = enc_j(53);
  endtask

  // one reference step: compare current ports, then commit
  task automatic step_and_check();
    logic [31:0] ins, a, b, imm, res, addr, npc;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    bit          ill, ovf, rwe, dwe;
    int          wa;
    logic [31:0] wd;
    string       tag, ptag;
    ins = im[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    imm = {{16{ins[15]}}, ins[15:0]};
    a = rf[rs]; b = rf[rt];
    npc = m_pc + 32'd4; ill = 0; ovf = 0; rwe = 0; dwe = 0; wa = 0; wd = '0; res = '0;
    addr = a + imm;
    tag = "R3"; ptag = "R2";
    case (op)
      6'b000000: begin
        case (fn)
          6'd32: begin res = a + b; ovf = (a[31] == b[31]) && (res[31] != a[31]); end
          6'd34: begin res = a - b; ovf = (a[31] != b[31]) && (res[31] != a[31]); end
          6'd36: res = a & b;
          6'd37: res = a | b;
          6'd39: res = ~(a | b);
          6'd42: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ill = 1;
        endcase
        rwe = !ill && !ovf; wa = rd; wd = res;
        if (rd == 0 || rs == 0 || rt == 0) tag = "R8";
        if (prev_w > 0 && (rs == prev_w || rt == prev_w)) tag = "R11";
        if (ovf) tag = "R10";
        if (ill) tag = "R9";
      end
      6'b100011: begin rwe = 1; wa = rt; wd = dm[addr[7:2]]; tag = "R4"; end
      6'b101011: begin dwe = 1; tag = "R5"; end
      6'b000100: begin
        tag = "R6"; ptag = "R6";
        if (a == b) npc = m_pc + 32'd4 + {imm[29:0], 2'b00};
      end
      6'b000010: begin tag = "R7"; ptag = "R7"; npc = {m_pc[31:28], ins[25:0], 2'b00}; end
      default: begin ill = 1; tag = "R9"; end
    endcase
    chk(ptag, "pc", pc_o, m_pc);
    chk(tag, "rf_we", 32'(rf_we_o), 32'(rwe));
    chk(tag, "dm_we", 32'(dm_we_o), 32'(dwe));
    chk(tag, "illegal", 32'(illegal_o), 32'(ill));
    chk(tag, "ovf", 32'(ovf_o), 32'(ovf));
    if (rwe) begin
      chk(tag, "waddr", 32'(rf_waddr_o), 32'(wa));
      chk(tag, "wdata", rf_wdata_o, wd);
    end
    if (dwe) begin
      chk(tag, "daddr", dm_addr_o, addr);
      chk(tag, "dwdata", dm_wdata_o, b);
    end
    if (rwe && wa != 0) rf[wa] = wd;
    if (dwe) dm[addr[7:2]] = b;
    prev_w = rwe ? wa : -1;
    m_pc = npc;
  endtask

  initial begin
    rst_n = 1'b1; ld_imem_we = 1'b0; ld_dmem_we = 1'b0; ld_idx = '0; ld_data = '0;
    #3 rst_n = 1'b0;
    build_prog();
    for (int r = 0; r < 32; r++) rf[r] = '0;
    @(negedge clk);
    for (int i = 0; i < NW; i++) begin
      ld_imem_we = 1'b1; ld_dmem_we = 1'b1; ld_idx = 6'(i);
      ld_data = im[i];
      @(negedge clk);
      ld_imem_we = 1'b0;
      ld_data = dm[i];
      @(negedge clk);
      ld_dmem_we = 1'b0;
    end
    // R1 during reset
    chk("R1", "pc in reset", pc_o, 32'd0);
    chk("R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
    chk("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "pc one edge after release", pc_o, 32'd0);
    chk("R1", "dm_we held after release", 32'(dm_we_o), 32'd0);
    @(posedge clk);
    @(negedge clk);
    m_pc = 32'd0;
    for (int c = 0; c < 80; c++) begin
      step_and_check();
      @(negedge clk);
    end
    // wrapped store landed in word 0, read back by the load at 52 (checked above)
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule